// File: doc/BRIEF.md
# Bypass-Aware Pipeline Stall Counter

This block watches a stream of retired instructions from a five-stage in-order pipeline (fetch, decode, execute, memory, writeback) and works out, for each one, how many bubble cycles a read-after-write data hazard costs it. Each instruction arrives already decoded. It carries a load flag, a store flag, two source register fields and one destination register field, each with its own valid bit. Three independent enable inputs choose which forwarding paths the modelled pipeline has: memory-to-execute (MX), writeback-to-execute (WX) and writeback-to-memory (WM). Any of the eight combinations can be selected.

The unit remembers the two most recent instructions. When stalls are inserted they push older producers further away, so an instruction that stalled removes its predecessor from the hazard window. Alongside the per-instruction stall value, the unit keeps a running instruction count and a running cycle total. The cycle total includes the four-cycle pipeline fill.

Top module: `bypass_stall_counter`

## Requirements
- R1: After reset, `stall_vld` is 0 and both `insn_count` and `cycle_count` read 0.
- R2: With no path enabled, a source that matches the destination of the previous instruction costs 2 stalls. A match with the instruction two back costs 1 stall. An older match costs nothing.
- R3: With MX enabled, a non-load producer one instruction back costs 0 stalls. A load producer one back costs 2 stalls when only MX is on and 1 stall when MX and WX are both on.
- R4: With WX enabled, a producer two back costs 0 stalls. A non-load producer one back without MX costs 1 stall, and no instruction ever costs 2 stalls.
- R5: With WM enabled, the data operand of a store (source B, `src_b`) costs 0 stalls against any producer one or two back. The address operand of a store (source A) follows the execute-stage rules of R2 to R4.
- R6: A source field whose valid bit is 0, or a producer whose destination valid bit is 0, never causes a stall.
- R7: When both earlier instructions write the same register, only the most recent one is used to compute the stall.
- R8: When an instruction stalls by 1 or more cycles, its predecessor no longer counts as two back for the next instruction.
- R9: Each accepted instruction adds 1 to `insn_count`. Once at least one instruction has been seen, `cycle_count` equals `insn_count` plus all stalls reported so far plus 4.
- R10: `stall_vld` and `stall_out` appear on the clock edge that accepts the instruction. A cycle with `in_valid` low changes neither the counts nor the history.
- R11: An instruction's stall is the larger of the stalls its two source operands would need.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | An instruction is presented this cycle |
| is_load | input | 1 | Instruction reads data memory into its destination |
| is_store | input | 1 | Instruction writes data memory; source B is the store data |
| src_a_vld | input | 1 | Source A field is present |
| src_a | input | REG_W | Source A register (address/base for memory operations) |
| src_b_vld | input | 1 | Source B field is present |
| src_b | input | REG_W | Source B register |
| dst_vld | input | 1 | Destination field is present |
| dst | input | REG_W | Destination register |
| en_mx | input | 1 | Enable memory-to-execute forwarding |
| en_wx | input | 1 | Enable writeback-to-execute forwarding |
| en_wm | input | 1 | Enable writeback-to-memory forwarding |
| stall_vld | output | 1 | `stall_out` holds the result for the last accepted instruction |
| stall_out | output | 2 | Stall cycles charged to that instruction (0 to 2) |
| insn_count | output | CNT_W | Instructions accepted since reset |
| cycle_count | output | CNT_W | Total cycles, including the fill; 0 before the first instruction |

## Verification
Every result is registered once. The stall value, its valid flag and both counters for an instruction presented in one cycle are therefore due on the next rising edge. The bench drives each instruction on a falling edge and reads the outputs on the following falling edge, exactly one edge later. Because instructions go in back to back, the result of instruction n is read in the same half-cycle in which instruction n+1 is driven. Counter totals are read the same way, after the last instruction of a stream has been clocked in.

// File: rtl/bsc_pkg.sv
package bsc_pkg;
  localparam int REG_IDX_W = 5;
  localparam int STALL_W   = 2;

  typedef logic [STALL_W-1:0] stall_t;

  // One remembered producer
  typedef struct packed {
    logic                 vld;
    logic [REG_IDX_W-1:0] dst;
    logic                 load;
  } prod_t;
endpackage

// File: rtl/bsc_operand_stall.sv
module bsc_operand_stall
  import bsc_pkg::*;
(
  input  logic                 src_vld,
  input  logic [REG_IDX_W-1:0] src,
  input  logic                 wm_data,  // store data operand with WM enabled
  input  logic                 en_mx,
  input  logic                 en_wx,
  input  prod_t                near,     // producer one back
  input  prod_t                far,      // producer two back
  output stall_t               stall
);
  logic hit_near, hit_far, ok_d1_early, ok_d1_late, ok_d2;

  always_comb begin
    hit_near    = src_vld && near.vld && (near.dst == src);
    hit_far     = src_vld && far.vld  && (far.dst  == src) && !hit_near;
    // consumer execute in the producer's memory cycle
    ok_d1_early = (en_mx && !near.load) || wm_data;
    // consumer execute in the producer's writeback cycle
    ok_d1_late  = en_wx || wm_data;
    ok_d2       = en_wx || wm_data;
    stall       = '0;
    if (hit_near) begin
      if (ok_d1_early)     stall = stall_t'(0);
      else if (ok_d1_late) stall = stall_t'(1);
      else                 stall = stall_t'(2);
    end else if (hit_far) begin
      stall = ok_d2 ? stall_t'(0) : stall_t'(1);
    end
  end
endmodule

// File: rtl/bsc_tally.sv
module bsc_tally
  import bsc_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int FILL  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  stall_t           stall,
  output logic [CNT_W-1:0] insn_count,
  output logic [CNT_W-1:0] cycle_count
);
  logic [CNT_W-1:0] insn_q, insn_d, acc_q, acc_d;

  always_comb begin
    insn_d = insn_q;
    acc_d  = acc_q;
    if (step) begin
      insn_d = insn_q + CNT_W'(1);
      acc_d  = acc_q + CNT_W'(1) + CNT_W'(stall);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      insn_q <= '0;
      acc_q  <= '0;
    end else if (step) begin
      insn_q <= insn_d;
      acc_q  <= acc_d;
    end
  end

  assign insn_count  = insn_q;
  assign cycle_count = (insn_q == '0) ? '0 : acc_q + CNT_W'(FILL);
endmodule

// File: rtl/bypass_stall_counter.sv
module bypass_stall_counter
  import bsc_pkg::*;
#(
  parameter int REG_W = bsc_pkg::REG_IDX_W,
  parameter int CNT_W = 32,
  parameter int FILL  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic             is_load,
  input  logic             is_store,
  input  logic             src_a_vld,
  input  logic [REG_W-1:0] src_a,
  input  logic             src_b_vld,
  input  logic [REG_W-1:0] src_b,
  input  logic             dst_vld,
  input  logic [REG_W-1:0] dst,
  input  logic             en_mx,
  input  logic             en_wx,
  input  logic             en_wm,
  output logic             stall_vld,
  output logic [1:0]       stall_out,
  output logic [CNT_W-1:0] insn_count,
  output logic [CNT_W-1:0] cycle_count
);
  localparam int NOPS = 2;

  prod_t  near_q, far_q, near_d, far_d;
  stall_t op_stall [NOPS];
  stall_t stall_d, stall_q;
  logic   vld_q;

  logic             op_vld [NOPS];
  logic [REG_W-1:0] op_reg [NOPS];
  logic             op_wm  [NOPS];

  always_comb begin
    op_vld[0] = src_a_vld;  op_reg[0] = src_a;  op_wm[0] = 1'b0;
    op_vld[1] = src_b_vld;  op_reg[1] = src_b;  op_wm[1] = is_store && en_wm;
  end

  for (genvar g = 0; g < NOPS; g++) begin : g_op
    bsc_operand_stall u_op (
      .src_vld (op_vld[g]),
      .src     (op_reg[g]),
      .wm_data (op_wm[g]),
      .en_mx   (en_mx),
      .en_wx   (en_wx),
      .near    (near_q),
      .far     (far_q),
      .stall   (op_stall[g])
    );
  end

  always_comb begin
    stall_d    = (op_stall[0] > op_stall[1]) ? op_stall[0] : op_stall[1];
    near_d.vld  = dst_vld;
    near_d.dst  = dst;
    near_d.load = is_load;
    // bubbles push the previous producer out of reach
    far_d       = near_q;
    if (stall_d != '0) far_d.vld = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      near_q  <= '0;
      far_q   <= '0;
      stall_q <= '0;
    end else if (in_valid) begin
      near_q  <= near_d;
      far_q   <= far_d;
      stall_q <= stall_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= 1'b0;
    else        vld_q <= in_valid;
  end

  bsc_tally #(.CNT_W(CNT_W), .FILL(FILL)) u_tally (
    .clk         (clk),
    .rst_n       (rst_n),
    .step        (in_valid),
    .stall       (stall_d),
    .insn_count  (insn_count),
    .cycle_count (cycle_count)
  );

  assign stall_vld = vld_q;
  assign stall_out = stall_q;
endmodule

// File: rtl/bsc_checker.sv
module bsc_checker #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             en_wx,
  input logic             stall_vld,
  input logic [1:0]       stall_out,
  input logic [CNT_W-1:0] insn_count,
  input logic [CNT_W-1:0] cycle_count
);
  p_result_valid_r10: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> stall_vld);

  p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!stall_vld && $stable(insn_count) && $stable(cycle_count)));

  p_count_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> insn_count == $past(insn_count) + CNT_W'(1));

  p_cycle_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (stall_vld && $past(insn_count) != '0) |->
      cycle_count == $past(cycle_count) + CNT_W'(1) + CNT_W'(stall_out));

  p_wx_cap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (stall_vld && $past(en_wx)) |-> stall_out != 2'd2);

  p_stall_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    stall_vld |-> stall_out <= 2'd2);
endmodule

bind bypass_stall_counter bsc_checker #(.CNT_W(CNT_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_valid    (in_valid),
  .en_wx       (en_wx),
  .stall_vld   (stall_vld),
  .stall_out   (stall_out),
  .insn_count  (insn_count),
  .cycle_count (cycle_count)
);

// File: tb/sim_bypass_stall_counter.sv
module sim_bypass_stall_counter;
  localparam int CLK_PERIOD = 10;
  localparam int REG_W = 5;
  localparam int CNT_W = 32;

  logic clk, rst_n, in_valid, is_load, is_store;
  logic src_a_vld, src_b_vld, dst_vld;
  logic [REG_W-1:0] src_a, src_b, dst;
  logic en_mx, en_wx, en_wm;
  logic stall_vld;
  logic [1:0] stall_out;
  logic [CNT_W-1:0] insn_count, cycle_count;

  int n_chk, n_fail;
  bit done;

  // reference model state
  int  hx [2];
  bit  hv [2];
  int  hd [2];
  bit  hl [2];
  int  lastx, m_insn, m_stalls;

  bypass_stall_counter u0 (.*);

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < 2; i++) begin hx[i] = 0; hv[i] = 0; hd[i] = 0; hl[i] = 0; end
    lastx = 0; m_insn = 0; m_stalls = 0;
  endtask

  // Timing model: absolute execute cycles of producers
  task automatic model_step(input bit ld, input bit st, input bit va, input int a,
                            input bit vb, input int b, input bit vd, input int d,
                            output int s);
    int x, need, px, t, p;
    bit ok3, ok4;
    x = lastx + 1;
    need = x;
    for (int op = 0; op < 2; op++) begin
      bit v; int r;
      v = (op == 0) ? va : vb;
      r = (op == 0) ? a : b;
      p = -1;
      if (v && hv[0] && hd[0] == r) p = 0;
      else if (v && hv[1] && hd[1] == r) p = 1;
      if (p >= 0) begin
        px = hx[p];
        ok3 = (en_mx && !hl[p]) || (op == 1 && st && en_wm);
        ok4 = en_wx || (op == 1 && st && en_wm);
        t = x;
        while (!((t == px + 1 && ok3) || (t == px + 2 && ok4) || t >= px + 3)) t++;
        if (t > need) need = t;
      end
    end
    s = need - x;
    hx[1] = hx[0]; hv[1] = hv[0]; hd[1] = hd[0]; hl[1] = hl[0];
    hx[0] = need;  hv[0] = vd;    hd[0] = d;     hl[0] = ld;
    lastx = need;
    m_insn++;
    m_stalls += s;
  endtask

  task automatic do_reset(input bit mx, input bit wx, input bit wm);
    in_valid = 0; is_load = 0; is_store = 0;
    src_a_vld = 0; src_b_vld = 0; dst_vld = 0; src_a = 0; src_b = 0; dst = 0;
    en_mx = mx; en_wx = wx; en_wm = wm;
    rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    model_reset();
    check("R1 stall_vld", stall_vld, 0);
    check("R1 insn_count", insn_count, 0);
    check("R1 cycle_count", cycle_count, 0);
  endtask

  // drive at a falling edge, sample at the next falling edge; exp<0 uses the model
  task automatic send(input string req, input bit ld, input bit st,
                      input bit va, input int a, input bit vb, input int b,
                      input bit vd, input int d, input int exp);
    int s;
    model_step(ld, st, va, a, vb, b, vd, d, s);
    in_valid = 1; is_load = ld; is_store = st;
    src_a_vld = va; src_a = REG_W'(a); src_b_vld = vb; src_b = REG_W'(b);
    dst_vld = vd; dst = REG_W'(d);
    @(negedge clk);
    in_valid = 0;
    check(req, stall_vld, 1);
    check(req, stall_out, (exp < 0) ? s : exp);
  endtask

  task automatic check_totals(input string req);
    check(req, insn_count, m_insn);
    check(req, cycle_count, (m_insn == 0) ? 0 : m_insn + m_stalls + 4);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    n_chk = 0; n_fail = 0; done = 0;
    void'($urandom(32'd20231));

    // R2: no bypassing
    do_reset(0, 0, 0);
    send("R2 first", 0, 0, 0, 0, 0, 0, 1, 1, 0);
    send("R2 dist1", 0, 0, 1, 1, 0, 0, 1, 2, 2);
    send("R2 filler", 0, 0, 0, 0, 0, 0, 1, 7, 0);
    send("R2 dist2", 0, 0, 1, 2, 0, 0, 0, 0, 1);
    send("R2 dist3", 0, 0, 1, 2, 0, 0, 0, 0, 0);
    check_totals("R9 after directed R2");
    // R10: idle cycle leaves counts alone
    @(negedge clk);
    check("R10 idle valid", stall_vld, 0);
    check_totals("R10 idle counts");

    // R3: MX
    do_reset(1, 0, 0);
    send("R3 alu prod", 0, 0, 0, 0, 0, 0, 1, 3, 0);
    send("R3 mx alu d1", 0, 0, 1, 3, 0, 0, 0, 0, 0);
    send("R3 load prod", 1, 0, 1, 9, 0, 0, 1, 4, 0);
    send("R3 mx-only load d1", 0, 0, 0, 0, 1, 4, 0, 0, 2);
    do_reset(1, 1, 0);
    send("R3 load prod", 1, 0, 1, 9, 0, 0, 1, 4, 0);
    send("R3 mx+wx load d1", 0, 0, 1, 4, 0, 0, 0, 0, 1);

    // R4: WX
    do_reset(0, 1, 0);
    send("R4 prod", 0, 0, 0, 0, 0, 0, 1, 5, 0);
    send("R4 wx alu d1", 0, 0, 1, 5, 0, 0, 1, 6, 1);
    send("R4 filler", 0, 0, 0, 0, 0, 0, 0, 0, 0);
    send("R4 wx d2", 0, 0, 1, 6, 0, 0, 0, 0, 0);

    // R5: WM
    do_reset(0, 0, 1);
    send("R5 load prod", 1, 0, 1, 9, 0, 0, 1, 1, 0);
    send("R5 store data", 0, 1, 1, 8, 1, 1, 0, 0, 0);
    do_reset(0, 0, 1);
    send("R5 load prod", 1, 0, 1, 9, 0, 0, 1, 1, 0);
    send("R5 store addr", 0, 1, 1, 1, 1, 8, 0, 0, 2);

    // R6: absent fields
    do_reset(0, 0, 0);
    send("R6 prod", 0, 0, 0, 0, 0, 0, 1, 2, 0);
    send("R6 src invalid", 0, 0, 0, 2, 0, 2, 0, 2, 0);
    send("R6 dst invalid", 0, 0, 1, 2, 1, 2, 0, 0, 1);

    // R7: newest producer wins
    do_reset(1, 0, 0);
    send("R7 old", 1, 0, 0, 0, 0, 0, 1, 2, 0);
    send("R7 new", 0, 0, 0, 0, 0, 0, 1, 2, 0);
    send("R7 use", 0, 0, 1, 2, 0, 0, 0, 0, 0);

    // R8: stalls shift history
    do_reset(0, 0, 0);
    send("R8 p", 0, 0, 0, 0, 0, 0, 1, 3, 0);
    send("R8 stall", 0, 0, 1, 3, 0, 0, 1, 5, 2);
    send("R8 shifted", 0, 0, 1, 3, 0, 0, 0, 0, 0);

    // R11: max over operands
    do_reset(0, 0, 0);
    send("R11 p1", 0, 0, 0, 0, 0, 0, 1, 1, 0);
    send("R11 p2", 0, 0, 0, 0, 0, 0, 1, 2, 0);
    send("R11 both", 0, 0, 1, 2, 1, 1, 0, 0, 2);
    check_totals("R9 after R11");

    // random streams in all configurations (R2..R9, R11)
    for (int cfg = 0; cfg < 8; cfg++) begin
      do_reset(cfg[0], cfg[1], cfg[2]);
      for (int k = 0; k < 400; k++) begin
        int kind;
        kind = $urandom % 4;
        case (kind)
          0: send("R11 rand alu", 0, 0, 1, $urandom % 4, 1, $urandom % 4, 1, $urandom % 4, -1);
          1: send("R3 rand load", 1, 0, 1, $urandom % 4, 0, 0, 1, $urandom % 4, -1);
          2: send("R5 rand store", 0, 1, 1, $urandom % 4, 1, $urandom % 4, 0, 0, -1);
          default: send("R2 rand imm", 0, 0, $urandom % 2, $urandom % 4, 0, 0,
                        $urandom % 2, $urandom % 4, -1);
        endcase
        if ($urandom % 16 == 0) @(negedge clk);
      end
      check_totals("R9 random totals");
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule